// File: doc/BRIEF.md
# Power Management Register Block

This block holds the fixed-function power management registers of a system: a free-running timer, a status register, an enable register and a control register. Software reaches them through a small port that carries 16-bit and 32-bit accesses. The block drives a level-sensitive system control interrupt (SCI). A write to the sleep field of the control register is turned into a shutdown request or a suspend-resume request. A second, byte-wide command/status port pair can switch the SCI enable on or off and can raise a system-management interrupt (SMI) request.

The timer is advanced by a tick of about 3.579545 MHz. By default a fractional accumulator derives that tick from the system clock. A parameter can select an external tick-enable input instead. All state clears on a synchronous active-high reset. The power button is modelled as a single-cycle input strobe.

Top module: `pwrmgmt_regblk`

## Requirements
- R1: After reset, status, enable, control, timer, command byte and scratch byte all read zero, and `sci`, `smi_req`, `shutdown_req` and `reset_req` are low.
- R2: The timer adds one for each tick and wraps modulo 2^TMR_W. A 32-bit read (`io_wide`=1) at offset 0x08 returns the timer in the low TMR_W bits, with all upper bits zero.
- R3: Status bit 0 is set in the cycle after each tick that carries the timer across a multiple of 2^(TMR_W-1).
- R4: A 16-bit write to the status register (offset 0x00) clears every bit written as 1 and leaves bits written as 0 unchanged. A set event in the same cycle as a clear of that bit wins, so the bit stays 1.
- R5: `sci` is 1 exactly when (status AND enable AND 0x0521) is nonzero. That mask covers bits 10, 8, 5 and 0, so status bit 15 alone never raises `sci`.
- R6: A 16-bit write to control (offset 0x04) with bit 13 set and bits 12:10 equal to 0 gives a one-cycle `shutdown_req` pulse in the cycle after the write. Control bit 13 always reads 0, and the other written bits are stored.
- R7: The same write with bits 12:10 equal to 1 sets status bits 15 and 8 and gives a one-cycle `reset_req` pulse in the cycle after the write.
- R8: With any other value in bits 12:10, or with bit 13 clear, the write changes no status bit and raises neither pulse.
- R9: Only the low six bits of `io_addr` are decoded. 16-bit accesses reach 0x00, 0x02 and 0x04, and a 32-bit read reaches only 0x08. Every other read returns 0, and 32-bit writes have no effect.
- R10: Writing 0xF1 to the command byte (`apm_sel`=0) sets control bit 0, writing 0xF0 clears it, and any other code leaves it unchanged. The command byte and the scratch byte (`apm_sel`=1) read back the last value written to them.
- R11: `smi_req` pulses for one cycle after a command-byte write only if `smi_en` is high during the write. Writes to the scratch byte never raise it.
- R12: A `pwrbtn_strobe` sets status bit 8 only while enable bit 8 is 1. When enable bit 8 is 0 the strobe changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | External timer tick enable, used when USE_EXT_TICK=1 |
| io_valid | input | 1 | Register port access strobe |
| io_write | input | 1 | 1 = write, 0 = read |
| io_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| io_addr | input | ADDR_W | Byte offset; only bits 5:0 are decoded |
| io_wdata | input | 32 | Write data; 16-bit writes use bits 15:0 |
| io_rdata | output | 32 | Read data, valid in the cycle of a read access |
| apm_wr | input | 1 | Command/status byte write strobe |
| apm_sel | input | 1 | 0 = command byte, 1 = scratch status byte |
| apm_wdata | input | 8 | Byte write data |
| apm_rdata | output | 8 | Byte selected by `apm_sel` |
| smi_en | input | 1 | Allows command writes to raise `smi_req` |
| pwrbtn_strobe | input | 1 | Power button event, one cycle |
| sci | output | 1 | Level system control interrupt |
| smi_req | output | 1 | One-cycle SMI request |
| shutdown_req | output | 1 | One-cycle soft-off request |
| reset_req | output | 1 | One-cycle suspend-resume reset request |

## Verification
The assertions rely on a few things about the inputs. Each register-port access lasts a single cycle. Two sleep-triggering control writes are never issued on consecutive cycles, so a request pulse is always followed by a low cycle. Tick, power-button and port strobes are synchronous to `clk`. The bench keeps within these limits: every access is driven at a falling edge and released at the next falling edge, and idle cycles separate the sleep writes. Ticks come from the external tick input with a 12-bit timer, so several overflow crossings fit into a short run.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    // register offsets within the decoded 6-bit window
    localparam logic [5:0] OFS_STS = 6'h00;
    localparam logic [5:0] OFS_EN  = 6'h02;
    localparam logic [5:0] OFS_CTL = 6'h04;
    localparam logic [5:0] OFS_TMR = 6'h08;

    // status / enable bit positions
    localparam int B_TMR  = 0;
    localparam int B_GBL  = 5;
    localparam int B_PWR  = 8;
    localparam int B_RTC  = 10;
    localparam int B_WAKE = 15;

    // control bit positions
    localparam int B_SCIEN  = 0;
    localparam int B_SLPGO  = 13;
    localparam int SLPT_LSB = 10;

    localparam logic [15:0] SCI_MASK = (16'h1 << B_RTC) | (16'h1 << B_PWR)
                                     | (16'h1 << B_GBL) | (16'h1 << B_TMR);
    localparam logic [15:0] STS_IMPL = SCI_MASK | (16'h1 << B_WAKE);

    // command byte codes
    localparam logic [7:0] CMD_SCI_ON  = 8'hF1;
    localparam logic [7:0] CMD_SCI_OFF = 8'hF0;

    typedef enum logic [2:0] {
        SLP_SOFT_OFF = 3'd0,
        SLP_RESUME   = 3'd1
    } slp_kind_e;

    typedef struct packed {
        logic shutdown;
        logic resume;
    } slp_act_t;

    typedef struct packed {
        logic        rd16;
        logic        wr16;
        logic        rd32;
        logic [5:0]  ofs;
        logic [15:0] data;
    } io_req_t;

    function automatic logic [15:0] w1c_merge(input logic [15:0] cur,
                                              input logic [15:0] clr,
                                              input logic [15:0] set);
        return ((cur & ~clr) | set) & STS_IMPL;
    endfunction

    function automatic slp_act_t decode_sleep(input logic [15:0] v);
        slp_act_t a;
        a = '0;
        if (v[B_SLPGO]) begin
            case (v[SLPT_LSB +: 3])
                SLP_SOFT_OFF: a.shutdown = 1'b1;
                SLP_RESUME:   a.resume   = 1'b1;
                default:      a = '0;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/pmr_tick_gen.sv
module pmr_tick_gen #(
    parameter bit          USE_EXT_TICK = 1'b0,
    parameter int unsigned CLK_HZ       = 100_000_000,
    parameter int unsigned TICK_HZ      = 3_579_545
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic tick
);
    generate
        if (USE_EXT_TICK) begin : g_ext
            logic unused_clk_rst;
            assign unused_clk_rst = &{1'b0, clk, rst};
            assign tick = tick_in;
        end else begin : g_frac
            localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;
            logic [ACC_W-1:0] acc_q;
            logic [ACC_W-1:0] sum;
            logic             wrap;
            logic             unused_tick_in;

            assign unused_tick_in = tick_in;
            assign sum  = acc_q + ACC_W'(TICK_HZ);
            assign wrap = (sum >= ACC_W'(CLK_HZ));

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_q <= '0;
                end else if (wrap) begin
                    acc_q <= sum - ACC_W'(CLK_HZ);
                end else begin
                    acc_q <= sum;
                end
            end
            assign tick = wrap;
        end
    endgenerate
endmodule

// File: rtl/pmr_timer.sv
module pmr_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [TMR_W-1:0] count,
    output logic             ovf_hit
);
    localparam int MSB = TMR_W - 1;

    logic [TMR_W-1:0] count_q;
    logic [TMR_W-1:0] count_nxt;

    assign count_nxt = count_q + TMR_W'(1);
    // a crossing of a multiple of 2^(TMR_W-1) flips the top bit
    assign ovf_hit   = tick && (count_nxt[MSB] != count_q[MSB]);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= count_nxt;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/pmr_apm.sv
module pmr_apm (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       sel,
    input  logic [7:0] wdata,
    input  logic       smi_en,
    output logic [7:0] rdata,
    output logic       sci_on,
    output logic       sci_off,
    output logic       smi_req
);
    import pmr_pkg::*;

    logic [7:0] cmd_q;
    logic [7:0] scratch_q;
    logic       smi_q;
    logic       cmd_wr;

    assign cmd_wr  = wr && !sel;
    assign sci_on  = cmd_wr && (wdata == CMD_SCI_ON);
    assign sci_off = cmd_wr && (wdata == CMD_SCI_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            scratch_q <= '0;
            smi_q     <= 1'b0;
        end else begin
            smi_q <= cmd_wr && smi_en;
            if (cmd_wr) begin
                cmd_q <= wdata;
            end
            if (wr && sel) begin
                scratch_q <= wdata;
            end
        end
    end

    assign rdata   = sel ? scratch_q : cmd_q;
    assign smi_req = smi_q;
endmodule

// File: rtl/pwrmgmt_regblk.sv
module pwrmgmt_regblk #(
    parameter int          ADDR_W       = 16,
    parameter int          TMR_W        = 24,
    parameter bit          USE_EXT_TICK = 1'b0,
    parameter int unsigned CLK_HZ       = 100_000_000,
    parameter int unsigned TICK_HZ      = 3_579_545
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_in,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic              io_wide,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    input  logic              apm_wr,
    input  logic              apm_sel,
    input  logic [7:0]        apm_wdata,
    output logic [7:0]        apm_rdata,
    input  logic              smi_en,
    input  logic              pwrbtn_strobe,
    output logic              sci,
    output logic              smi_req,
    output logic              shutdown_req,
    output logic              reset_req
);
    import pmr_pkg::*;

    logic             tick;
    logic [TMR_W-1:0] tmr_count;
    logic             ovf_hit;
    logic             sci_on;
    logic             sci_off;

    logic [15:0] sts_q;
    logic [15:0] en_q;
    logic [15:0] ctl_q;
    logic        shutdown_q;
    logic        reset_q;

    io_req_t     req;
    slp_act_t    slp;
    logic [15:0] sts_set;
    logic [15:0] sts_clr;
    logic        pwr_hit;
    logic        unused_io;

    // ---------------- sub-blocks
    pmr_tick_gen #(
        .USE_EXT_TICK (USE_EXT_TICK),
        .CLK_HZ       (CLK_HZ),
        .TICK_HZ      (TICK_HZ)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .tick_in (tick_in),
        .tick    (tick)
    );

    pmr_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .count   (tmr_count),
        .ovf_hit (ovf_hit)
    );

    pmr_apm u_apm (
        .clk     (clk),
        .rst     (rst),
        .wr      (apm_wr),
        .sel     (apm_sel),
        .wdata   (apm_wdata),
        .smi_en  (smi_en),
        .rdata   (apm_rdata),
        .sci_on  (sci_on),
        .sci_off (sci_off),
        .smi_req (smi_req)
    );

    // ---------------- access decode
    assign unused_io = &{1'b0, io_addr[ADDR_W-1:6], io_wdata[31:16]};

    always_comb begin
        req.ofs  = io_addr[5:0];
        req.data = io_wdata[15:0];
        req.wr16 = io_valid &&  io_write && !io_wide;
        req.rd16 = io_valid && !io_write && !io_wide;
        req.rd32 = io_valid && !io_write &&  io_wide;
    end

    assign slp     = (req.wr16 && req.ofs == OFS_CTL) ? decode_sleep(req.data) : '0;
    assign pwr_hit = pwrbtn_strobe && en_q[B_PWR];

    always_comb begin
        sts_set = '0;
        sts_set[B_TMR] = ovf_hit;
        sts_set[B_PWR] = pwr_hit || slp.resume;
        sts_set[B_WAKE] = slp.resume;
        sts_clr = (req.wr16 && req.ofs == OFS_STS) ? req.data : '0;
    end

    // ---------------- register state
    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q      <= '0;
            en_q       <= '0;
            ctl_q      <= '0;
            shutdown_q <= 1'b0;
            reset_q    <= 1'b0;
        end else begin
            sts_q      <= w1c_merge(sts_q, sts_clr, sts_set);
            shutdown_q <= slp.shutdown;
            reset_q    <= slp.resume;
            if (req.wr16 && req.ofs == OFS_EN) begin
                en_q <= req.data;
            end
            if (req.wr16 && req.ofs == OFS_CTL) begin
                ctl_q <= req.data & ~(16'h1 << B_SLPGO);
            end
            // the command port acts after the register port on bit 0
            if (sci_on) begin
                ctl_q[B_SCIEN] <= 1'b1;
            end else if (sci_off) begin
                ctl_q[B_SCIEN] <= 1'b0;
            end
        end
    end

    // ---------------- read mux
    always_comb begin
        io_rdata = '0;
        if (req.rd16) begin
            case (req.ofs)
                OFS_STS: io_rdata = {16'h0, sts_q};
                OFS_EN:  io_rdata = {16'h0, en_q};
                OFS_CTL: io_rdata = {16'h0, ctl_q};
                default: io_rdata = '0;
            endcase
        end else if (req.rd32 && req.ofs == OFS_TMR) begin
            io_rdata = 32'(tmr_count);
        end
    end

    assign sci          = |(sts_q & en_q & SCI_MASK);
    assign shutdown_req = shutdown_q;
    assign reset_req    = reset_q;
endmodule

// File: rtl/pmr_checker.sv
module pmr_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] sts_q,
    input logic [15:0] en_q,
    input logic [15:0] ctl_q,
    input logic        ovf_hit,
    input logic        sci,
    input logic        smi_req,
    input logic        smi_en,
    input logic        apm_wr,
    input logic        apm_sel,
    input logic [7:0]  apm_wdata,
    input logic        shutdown_req,
    input logic        reset_req
);
    p_ovf_sets_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_hit |=> sts_q[0]);

    p_sci_source_r5: assert property (@(posedge clk) disable iff (rst)
        sci |-> ((sts_q & en_q) != 16'h0));

    p_shutdown_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |=> !shutdown_req);

    p_reset_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    p_resume_status_r7: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (sts_q[15] && sts_q[8]));

    p_pulses_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(shutdown_req && reset_req));

    p_apm_on_r10: assert property (@(posedge clk) disable iff (rst)
        (apm_wr && !apm_sel && apm_wdata == 8'hF1) |=> ctl_q[0]);

    p_apm_off_r10: assert property (@(posedge clk) disable iff (rst)
        (apm_wr && !apm_sel && apm_wdata == 8'hF0) |=> !ctl_q[0]);

    p_smi_gated_r11: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $past(smi_en && apm_wr && !apm_sel));
endmodule

bind pwrmgmt_regblk pmr_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .sts_q        (sts_q),
    .en_q         (en_q),
    .ctl_q        (ctl_q),
    .ovf_hit      (ovf_hit),
    .sci          (sci),
    .smi_req      (smi_req),
    .smi_en       (smi_en),
    .apm_wr       (apm_wr),
    .apm_sel      (apm_sel),
    .apm_wdata    (apm_wdata),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req)
);

// File: tb/pwrmgmt_regblk_tb_top.sv
module pwrmgmt_regblk_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW         = 12;
    localparam int HALF       = 1 << (TW - 1);
    localparam int FULL       = 1 << TW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_in = 1'b0;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic        io_wide = 1'b0;
    logic [15:0] io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        apm_wr = 1'b0;
    logic        apm_sel = 1'b0;
    logic [7:0]  apm_wdata = '0;
    logic [7:0]  apm_rdata;
    logic        smi_en = 1'b0;
    logic        pwrbtn_strobe = 1'b0;
    logic        sci, smi_req, shutdown_req, reset_req;

    int checks = 0;
    int errors = 0;
    int tcount = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwrmgmt_regblk #(.TMR_W(TW), .USE_EXT_TICK(1'b1)) dut_i (
        .clk(clk), .rst(rst), .tick_in(tick_in),
        .io_valid(io_valid), .io_write(io_write), .io_wide(io_wide),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .apm_wr(apm_wr), .apm_sel(apm_sel), .apm_wdata(apm_wdata),
        .apm_rdata(apm_rdata), .smi_en(smi_en), .pwrbtn_strobe(pwrbtn_strobe),
        .sci(sci), .smi_req(smi_req), .shutdown_req(shutdown_req),
        .reset_req(reset_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [31:0] d, input logic wide);
        @(negedge clk);
        io_valid = 1'b1; io_write = 1'b1; io_wide = wide; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_valid = 1'b0; io_write = 1'b0; io_wide = 1'b0;
    endtask

    task automatic io_rd(input logic [15:0] a, input logic wide, output logic [31:0] d);
        @(negedge clk);
        io_valid = 1'b1; io_write = 1'b0; io_wide = wide; io_addr = a;
        #1 d = io_rdata;
        io_valid = 1'b0; io_wide = 1'b0;
    endtask

    task automatic apm_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        apm_wr = 1'b1; apm_sel = sel; apm_wdata = d;
        @(negedge clk);
        apm_wr = 1'b0;
    endtask

    task automatic apm_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        apm_sel = sel;
        #1 d = apm_rdata;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_in = 1'b1;
            repeat (n) @(negedge clk);
            tick_in = 1'b0;
            tcount += n;
        end
    endtask

    task automatic strobe_pwr();
        @(negedge clk);
        pwrbtn_strobe = 1'b1;
        @(negedge clk);
        pwrbtn_strobe = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [7:0]  b;
        io_rd(16'h00, 1'b0, d); chk("R1 status", d, 0);
        io_rd(16'h02, 1'b0, d); chk("R1 enable", d, 0);
        io_rd(16'h04, 1'b0, d); chk("R1 control", d, 0);
        io_rd(16'h08, 1'b1, d); chk("R1 timer", d, 0);
        apm_read(1'b0, b); chk("R1 cmd byte", 32'(b), 0);
        apm_read(1'b1, b); chk("R1 scratch byte", 32'(b), 0);
        chk("R1 outputs", {28'h0, sci, smi_req, shutdown_req, reset_req}, 0);
    endtask

    task automatic t_timer();
        logic [31:0] d;
        ticks(100);
        io_rd(16'h08, 1'b1, d); chk("R2 timer after 100", d, 32'(tcount % FULL));
        ticks(FULL - 100 + 5);
        io_rd(16'h08, 1'b1, d); chk("R2 timer wrap", d, 32'(tcount % FULL));
        chk("R2 upper bits zero", {20'h0, d[31:TW]}, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        int need;
        io_wr(16'h00, 32'hFFFF, 1'b0);
        io_wr(16'h02, 32'h0001, 1'b0);
        need = HALF - (tcount % HALF);
        ticks(need - 1);
        io_rd(16'h00, 1'b0, d); chk("R3 no ovf before crossing", d & 1, 0);
        chk("R5 sci low before ovf", 32'(sci), 0);
        ticks(1);
        io_rd(16'h00, 1'b0, d); chk("R3 ovf set at crossing", d, 32'h0001);
        chk("R5 sci on ovf", 32'(sci), 1);
        io_wr(16'h00, 32'h0001, 1'b0);
        io_rd(16'h00, 1'b0, d); chk("R4 ovf cleared by W1C", d, 0);
        chk("R5 sci after clear", 32'(sci), 0);
        io_wr(16'h02, 32'h0000, 1'b0);
    endtask

    task automatic t_pwrbtn();
        logic [31:0] d;
        strobe_pwr();
        io_rd(16'h00, 1'b0, d); chk("R12 strobe ignored when disabled", d, 0);
        chk("R12 sci stays low", 32'(sci), 0);
        io_wr(16'h02, 32'h0100, 1'b0);
        strobe_pwr();
        io_rd(16'h00, 1'b0, d); chk("R12 strobe sets bit 8", d, 32'h0100);
        chk("R5 sci on button", 32'(sci), 1);
        io_wr(16'h02, 32'h0000, 1'b0);
        chk("R5 sci masked by enable", 32'(sci), 0);
        io_wr(16'h02, 32'h0100, 1'b0);
        chk("R5 sci re-enabled", 32'(sci), 1);
        // same-cycle set and clear: set wins
        @(negedge clk);
        pwrbtn_strobe = 1'b1;
        io_valid = 1'b1; io_write = 1'b1; io_wide = 1'b0; io_addr = 16'h00; io_wdata = 32'h0100;
        @(negedge clk);
        pwrbtn_strobe = 1'b0; io_valid = 1'b0; io_write = 1'b0;
        io_rd(16'h00, 1'b0, d); chk("R4 set wins over clear", d, 32'h0100);
        io_wr(16'h00, 32'h0000, 1'b0);
        io_rd(16'h00, 1'b0, d); chk("R4 zero write keeps bit", d, 32'h0100);
        io_wr(16'h00, 32'h0100, 1'b0);
        io_rd(16'h00, 1'b0, d); chk("R4 clear bit 8", d, 0);
        io_wr(16'h02, 32'h0000, 1'b0);
    endtask

    task automatic t_sleep_off();
        logic [31:0] d;
        io_wr(16'h04, 32'h2000, 1'b0);
        chk("R6 shutdown pulse", 32'(shutdown_req), 1);
        chk("R6 no reset pulse", 32'(reset_req), 0);
        @(negedge clk);
        chk("R6 shutdown one cycle", 32'(shutdown_req), 0);
        io_rd(16'h04, 1'b0, d); chk("R6 bit 13 reads 0", d, 0);
    endtask

    task automatic t_sleep_resume();
        logic [31:0] d;
        io_wr(16'h04, 32'h2400, 1'b0);
        chk("R7 reset pulse", 32'(reset_req), 1);
        chk("R7 no shutdown", 32'(shutdown_req), 0);
        @(negedge clk);
        chk("R7 reset one cycle", 32'(reset_req), 0);
        io_rd(16'h00, 1'b0, d); chk("R7 status 15 and 8", d, 32'h8100);
        io_rd(16'h04, 1'b0, d); chk("R6 control stored without bit 13", d, 32'h0400);
        io_wr(16'h02, 32'h8421, 1'b0);
        io_wr(16'h02, 32'h8000, 1'b0);
        chk("R5 bit 15 alone no sci", 32'(sci), 0);
        io_wr(16'h02, 32'h0100, 1'b0);
        chk("R5 bit 8 raises sci", 32'(sci), 1);
        io_wr(16'h00, 32'hFFFF, 1'b0);
        io_wr(16'h02, 32'h0000, 1'b0);
    endtask

    task automatic t_sleep_other();
        logic [31:0] d;
        io_wr(16'h04, 32'h3400, 1'b0);
        chk("R8 type 5 no pulses", {30'h0, shutdown_req, reset_req}, 0);
        io_wr(16'h04, 32'h0400, 1'b0);
        chk("R8 no go bit no pulses", {30'h0, shutdown_req, reset_req}, 0);
        io_rd(16'h00, 1'b0, d); chk("R8 status untouched", d, 0);
        io_rd(16'h04, 1'b0, d); chk("R8 control stored", d, 32'h0400);
        io_wr(16'h04, 32'h0000, 1'b0);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        io_wr(16'h0042, 32'h1234, 1'b0);
        io_rd(16'h02, 1'b0, d); chk("R9 upper address bits ignored on write", d, 32'h1234);
        io_rd(16'hFFC2, 1'b0, d); chk("R9 upper address bits ignored on read", d, 32'h1234);
        io_rd(16'h06, 1'b0, d); chk("R9 unmapped reads 0", d, 0);
        io_rd(16'h02, 1'b1, d); chk("R9 32-bit read of enable is 0", d, 0);
        io_rd(16'h08, 1'b0, d); chk("R9 16-bit read of timer is 0", d, 0);
        io_wr(16'h02, 32'h0000FFFF, 1'b1);
        io_rd(16'h02, 1'b0, d); chk("R9 32-bit write ignored", d, 32'h1234);
        io_wr(16'h02, 32'h0000, 1'b0);
    endtask

    task automatic t_apm();
        logic [31:0] d;
        logic [7:0]  b;
        apm_write(1'b0, 8'hF1);
        io_rd(16'h04, 1'b0, d); chk("R10 0xF1 sets bit 0", d, 32'h0001);
        apm_write(1'b0, 8'h37);
        io_rd(16'h04, 1'b0, d); chk("R10 other code keeps bit 0", d, 32'h0001);
        apm_read(1'b0, b); chk("R10 cmd readback", 32'(b), 32'h37);
        apm_write(1'b1, 8'hA5);
        apm_read(1'b1, b); chk("R10 scratch readback", 32'(b), 32'hA5);
        apm_write(1'b0, 8'hF0);
        io_rd(16'h04, 1'b0, d); chk("R10 0xF0 clears bit 0", d, 0);
    endtask

    task automatic t_smi();
        smi_en = 1'b1;
        apm_write(1'b0, 8'h55);
        chk("R11 smi pulse when enabled", 32'(smi_req), 1);
        @(negedge clk);
        chk("R11 smi one cycle", 32'(smi_req), 0);
        apm_write(1'b1, 8'h55);
        chk("R11 scratch write no smi", 32'(smi_req), 0);
        smi_en = 1'b0;
        apm_write(1'b0, 8'h55);
        chk("R11 no smi when disabled", 32'(smi_req), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_timer();
        t_overflow();
        t_pwrbtn();
        t_sleep_off();
        t_sleep_resume();
        t_sleep_other();
        t_decode();
        t_apm();
        t_smi();
        t_overflow();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule